// File: doc/BRIEF.md
# Command-Processor Microcontroller ALU

This block is the arithmetic unit of a small microcontroller that parses a command stream. Each cycle it takes a 4-bit operation code, a first source value and a second operand. The second operand is either a second register value or a 16-bit immediate taken from the instruction. The 32-bit result is purely combinational. Instruction decode, the register file and branch resolution all sit outside this block.

A single carry flag is the only stored state. It makes 64-bit addition and subtraction possible as a low-half step followed by a high-half step. The caller gates each update of the flag with an enable. The compare operation does not return a signed difference. It returns one of three fixed codes, chosen so that a later single-bit test can tell less-or-equal apart from greater.

Top module: `cpalu_top`

## Requirements
- R1: The operation code `op_i` is encoded as 0 add, 1 add-high, 2 sub, 3 sub-high, 4 and, 5 or, 6 xor, 7 not, 8 shift-left, 9 unsigned shift-right, 10 signed shift-right, 11 rotate-left, 12 byte multiply, 13 min, 14 max, 15 compare. When `use_imm_i` is 1 the second operand is `imm_i` zero-extended to 32 bits. Otherwise it is `src_b_i`.
- R2: The and, or and xor operations give the bitwise combination of the first source and the second operand.
- R3: Add gives the 32-bit sum and a carry equal to the carry-out. Sub gives the 32-bit difference and a carry equal to 1 exactly when the first source is below the second operand, compared unsigned.
- R4: Add-high gives first + second + stored carry, with the new carry being the carry-out. Sub-high gives first - second - stored carry, with the new carry being 1 exactly when that difference is negative.
- R5: `carry_o` is 0 after reset. At a rising clock edge it takes the value from R3/R4 only when `carry_en_i` is 1 and the operation is add, add-high, sub or sub-high. Otherwise it holds.
- R6: Shift-left, unsigned shift-right and signed (sign-filling) shift-right move the first source by the low 5 bits of the second operand.
- R7: Rotate-left shifts the first source left by the low 5 bits of the second operand, and bits leaving bit 31 re-enter at bit 0.
- R8: Byte multiply gives the unsigned product of bits 7:0 of the first source and bits 7:0 of the second operand, zero-extended.
- R9: Min and max return the smaller or the larger of the two operands, compared unsigned.
- R10: Compare returns 0x00 when first > second, 0x2b when they are equal and 0x1e when first < second, compared unsigned.
- R11: Not returns the bitwise inverse of the second operand, and the first source has no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the carry flag |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| src_a_i | input | 32 | First source value |
| src_b_i | input | 32 | Second source register value |
| imm_i | input | 16 | Instruction immediate |
| use_imm_i | input | 1 | Selects the immediate as the second operand |
| carry_en_i | input | 1 | Allows the carry flag to update this cycle |
| result_o | output | 32 | Combinational result |
| carry_o | output | 1 | Stored carry/borrow flag |

## Verification
In a chained high-half operation, two things happen in the same cycle: the result is formed from the stored carry, and that same carry is being replaced at the coming edge. The bench drives add or sub directly followed by add-high or sub-high, with the enable on and off in every combination. It mixes these chained pairs into a random stream of all opcodes. Each cycle the result is judged against a reference that uses the carry from before the edge, and the flag is judged after the edge against the reference's update rule.

// File: rtl/cpalu_pkg.sv
package cpalu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDHI = 4'd1,
    OP_SUB   = 4'd2,
    OP_SUBHI = 4'd3,
    OP_AND   = 4'd4,
    OP_OR    = 4'd5,
    OP_XOR   = 4'd6,
    OP_NOT   = 4'd7,
    OP_SHL   = 4'd8,
    OP_SHRU  = 4'd9,
    OP_SHRS  = 4'd10,
    OP_ROTL  = 4'd11,
    OP_MUL8  = 4'd12,
    OP_MIN   = 4'd13,
    OP_MAX   = 4'd14,
    OP_CMP   = 4'd15
  } cpalu_op_e;

  // three-way compare codes: bit 1 is set for "equal" and "less"
  localparam logic [7:0] CMP_GT = 8'h00;
  localparam logic [7:0] CMP_EQ = 8'h2b;
  localparam logic [7:0] CMP_LT = 8'h1e;

endpackage

// File: rtl/cpalu_opsel.sv
module cpalu_opsel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] reg_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  output logic [DATA_W-1:0] op_b
);
  logic [DATA_W-1:0] imm_ext;

  generate
    if (IMM_W < DATA_W) begin : g_zext
      assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm};
    end else begin : g_trunc
      assign imm_ext = imm[DATA_W-1:0];
    end
  endgenerate

  assign op_b = use_imm ? imm_ext : reg_b;
endmodule

// File: rtl/cpalu_arith.sv
module cpalu_arith
  import cpalu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  cpalu_op_e         op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              carry_q,
  output logic [DATA_W-1:0] res,
  output logic              chain_op,
  output logic              carry_nxt
);
  function automatic logic [DATA_W:0] add_ext(input logic [DATA_W-1:0] x,
                                              input logic [DATA_W-1:0] y,
                                              input logic cin);
    return {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
  endfunction

  // the top bit of the widened difference is the borrow
  function automatic logic [DATA_W:0] sub_ext(input logic [DATA_W-1:0] x,
                                              input logic [DATA_W-1:0] y,
                                              input logic bin);
    return {1'b0, x} - {1'b0, y} - {{DATA_W{1'b0}}, bin};
  endfunction

  logic [DATA_W:0] wide;

  always_comb begin
    chain_op = 1'b1;
    unique case (op)
      OP_ADD:   wide = add_ext(a, b, 1'b0);
      OP_ADDHI: wide = add_ext(a, b, carry_q);
      OP_SUB:   wide = sub_ext(a, b, 1'b0);
      OP_SUBHI: wide = sub_ext(a, b, carry_q);
      default: begin
        wide     = '0;
        chain_op = 1'b0;
      end
    endcase
  end

  assign res       = wide[DATA_W-1:0];
  assign carry_nxt = wide[DATA_W];
endmodule

// File: rtl/cpalu_bitops.sv
module cpalu_bitops
  import cpalu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MUL_W  = 8
) (
  input  cpalu_op_e         op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);
  localparam int SH_W = $clog2(DATA_W);

  function automatic logic [DATA_W-1:0] rotl(input logic [DATA_W-1:0] x,
                                             input logic [SH_W-1:0] n);
    logic [2*DATA_W-1:0] dbl;
    dbl = {x, x} << n;
    return dbl[2*DATA_W-1:DATA_W];
  endfunction

  function automatic logic [DATA_W-1:0] mul_low(input logic [MUL_W-1:0] x,
                                                input logic [MUL_W-1:0] y);
    logic [2*MUL_W-1:0] p;
    p = x * y;
    return {{(DATA_W-2*MUL_W){1'b0}}, p};
  endfunction

  logic [SH_W-1:0] sh;
  assign sh = b[SH_W-1:0];

  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOT:  res = ~b;
      OP_SHL:  res = a << sh;
      OP_SHRU: res = a >> sh;
      OP_SHRS: res = $unsigned($signed(a) >>> sh);
      OP_ROTL: res = rotl(a, sh);
      OP_MUL8: res = mul_low(a[MUL_W-1:0], b[MUL_W-1:0]);
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/cpalu_order.sv
module cpalu_order
  import cpalu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  cpalu_op_e         op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);
  function automatic logic [7:0] cmp3(input logic [DATA_W-1:0] x,
                                      input logic [DATA_W-1:0] y);
    if (x == y)     return CMP_EQ;
    else if (x < y) return CMP_LT;
    else            return CMP_GT;
  endfunction

  logic a_lt_b;
  assign a_lt_b = a < b;

  always_comb begin
    unique case (op)
      OP_MIN:  res = a_lt_b ? a : b;
      OP_MAX:  res = a_lt_b ? b : a;
      OP_CMP:  res = {{(DATA_W-8){1'b0}}, cmp3(a, b)};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/cpalu_top.sv
module cpalu_top
  import cpalu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int MUL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  input  logic              carry_en_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  cpalu_op_e         op;
  logic [DATA_W-1:0] op_b;
  logic [DATA_W-1:0] arith_res, bit_res, ord_res;
  logic              chain_op, carry_nxt, carry_upd, carry_q;

  assign op = cpalu_op_e'(op_i);

  cpalu_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .reg_b(src_b_i), .imm(imm_i), .use_imm(use_imm_i), .op_b(op_b)
  );

  cpalu_arith #(.DATA_W(DATA_W)) u_arith (
    .op(op), .a(src_a_i), .b(op_b), .carry_q(carry_q),
    .res(arith_res), .chain_op(chain_op), .carry_nxt(carry_nxt)
  );

  cpalu_bitops #(.DATA_W(DATA_W), .MUL_W(MUL_W)) u_bitops (
    .op(op), .a(src_a_i), .b(op_b), .res(bit_res)
  );

  cpalu_order #(.DATA_W(DATA_W)) u_order (
    .op(op), .a(src_a_i), .b(op_b), .res(ord_res)
  );

  // each unit drives zero outside its own operations
  assign result_o  = arith_res | bit_res | ord_res;
  assign carry_upd = chain_op & carry_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         carry_q <= 1'b0;
    else if (carry_upd) carry_q <= carry_nxt;
  end

  assign carry_o = carry_q;
endmodule

// File: rtl/cpalu_checker.sv
module cpalu_checker
  import cpalu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] src_a_i,
  input logic              use_imm_i,
  input logic              carry_en_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o,
  input logic [DATA_W-1:0] op_b,
  input logic              carry_upd
);
  // R5
  carry_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_en_i |=> $stable(carry_o));

  // R5
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_upd |=> $stable(carry_o));

  // R3
  add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ADD && carry_en_i) |=> carry_o == ($past(result_o) < $past(src_a_i)));

  // R1
  imm_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (use_imm_i && op_i == OP_AND) |-> result_o[DATA_W-1:16] == '0);

  // R11
  not_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (use_imm_i && op_i == OP_NOT) |-> &result_o[DATA_W-1:16]);

  // R8
  mul8_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == OP_MUL8 |-> result_o[DATA_W-1:16] == '0);

  // R9
  min_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == OP_MIN |-> ((result_o == src_a_i || result_o == op_b) &&
                        result_o <= src_a_i && result_o <= op_b));

  // R10
  cmp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == OP_CMP |-> (result_o == 32'h0 || result_o == 32'h2b || result_o == 32'h1e));
endmodule

bind cpalu_top cpalu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .src_a_i(src_a_i),
  .use_imm_i(use_imm_i), .carry_en_i(carry_en_i), .result_o(result_o),
  .carry_o(carry_o), .op_b(op_b), .carry_upd(carry_upd)
);

// File: tb/tb_cpalu_top.sv
module tb_cpalu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] src_a_i = '0, src_b_i = '0;
  logic [15:0] imm_i = '0;
  logic        use_imm_i = 1'b0, carry_en_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o;

  int checks = 0, fails = 0;
  bit model_c = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cpalu_top dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .src_a_i(src_a_i),
    .src_b_i(src_b_i), .imm_i(imm_i), .use_imm_i(use_imm_i),
    .carry_en_i(carry_en_i), .result_o(result_o), .carry_o(carry_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (op %0d)", tag, got, exp, op_i);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0, 2:    return "R3";
      1, 3:    return "R4";
      4, 5, 6: return "R2";
      7:       return "R11";
      8, 9, 10: return "R6";
      11:      return "R7";
      12:      return "R8";
      13, 14:  return "R9";
      default: return "R10";
    endcase
  endfunction

  // behavioural reference, 64-bit arithmetic
  task automatic ref_eval(input int op, input logic [31:0] a, input logic [31:0] b,
                          input bit cin, output logic [31:0] r, output bit cout,
                          output bit chain);
    longint unsigned la = a, lb = b, t;
    int sh = int'(b % 32);
    int signed sa = a;
    chain = (op <= 3);
    cout = 1'b0;
    case (op)
      0: begin t = la + lb; r = t[31:0]; cout = t[32]; end
      1: begin t = la + lb + cin; r = t[31:0]; cout = t[32]; end
      2: begin r = a - b; cout = (la < lb); end
      3: begin r = a - b - cin; cout = (la < lb + cin); end
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: r = ~b;
      8: begin t = la << sh; r = t[31:0]; end
      9: r = a >> sh;
      10: r = sa >>> sh;
      11: begin t = la << sh; r = t[31:0] | t[63:32]; end
      12: r = (a & 32'hff) * (b & 32'hff);
      13: r = (la < lb) ? a : b;
      14: r = (la > lb) ? a : b;
      default: r = (a == b) ? 32'h2b : ((la < lb) ? 32'h1e : 32'h0);
    endcase
  endtask

  task automatic step(input int op, input logic [31:0] a, input logic [31:0] rb,
                      input logic [15:0] imm, input bit use_imm, input bit en,
                      input string tag);
    logic [31:0] b, exp_r;
    bit cout, chain;
    @(negedge clk);
    op_i = op[3:0]; src_a_i = a; src_b_i = rb; imm_i = imm;
    use_imm_i = use_imm; carry_en_i = en;
    #1;
    b = use_imm ? {16'h0, imm} : rb;
    ref_eval(op, a, b, model_c, exp_r, cout, chain);
    check((tag == "") ? tag_of(op) : tag, result_o, exp_r);
    check("R5", {31'h0, carry_o}, {31'h0, model_c});
    @(posedge clk);
    if (chain && en) model_c = cout;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R5", {31'h0, carry_o}, 32'h0);   // reset state
    rst_n = 1'b1;

    // R1: immediate zero-extended; register path when flag low
    step(4, 32'hffff_ffff, 32'h1234_5678, 16'hffff, 1'b1, 1'b0, "R1");
    step(4, 32'hffff_ffff, 32'h1234_5678, 16'hffff, 1'b0, 1'b0, "R1");
    // R3: carry-out and borrow
    step(0, 32'hffff_ffff, 32'h1, 16'h0, 1'b0, 1'b1, "R3");
    // R4: high half consumes it (0+0+1)
    step(1, 32'h0, 32'h0, 16'h0, 1'b0, 1'b1, "R4");
    step(2, 32'h0, 32'h1, 16'h0, 1'b0, 1'b1, "R3");
    step(3, 32'h5, 32'h2, 16'h0, 1'b0, 1'b1, "R4");
    step(3, 32'h0, 32'h0, 16'h0, 1'b0, 1'b0, "R4");
    // R5: enable low keeps flag; non-chain op with enable high keeps flag
    step(0, 32'hffff_ffff, 32'hffff_ffff, 16'h0, 1'b0, 1'b0, "R5");
    step(6, 32'hffff_ffff, 32'hffff_ffff, 16'h0, 1'b0, 1'b1, "R5");
    step(2, 32'h1, 32'h3, 16'h0, 1'b0, 1'b1, "R5");
    step(5, 32'h0, 32'h0, 16'h0, 1'b0, 1'b1, "R5");
    step(1, 32'hffff_fffe, 32'h1, 16'h0, 1'b0, 1'b1, "R4");
    // R6: only low 5 bits of amount count
    step(8, 32'h8000_0001, 32'h21, 16'h0, 1'b0, 1'b0, "R6");
    step(10, 32'h8000_0000, 32'h4, 16'h0, 1'b0, 1'b0, "R6");
    step(9, 32'h8000_0000, 32'h0, 16'h1f, 1'b1, 1'b0, "R6");
    // R7
    step(11, 32'h8000_0001, 32'h1, 16'h0, 1'b0, 1'b0, "R7");
    step(11, 32'hdead_beef, 32'h0, 16'h0, 1'b0, 1'b0, "R7");
    // R8
    step(12, 32'h1ff, 32'h2ff, 16'h0, 1'b0, 1'b0, "R8");
    // R9 unsigned ordering
    step(13, 32'h8000_0000, 32'h1, 16'h0, 1'b0, 1'b0, "R9");
    step(14, 32'h8000_0000, 32'h1, 16'h0, 1'b0, 1'b0, "R9");
    // R10 three cases
    step(15, 32'h5, 32'h3, 16'h0, 1'b0, 1'b0, "R10");
    step(15, 32'h7, 32'h7, 16'h0, 1'b0, 1'b0, "R10");
    step(15, 32'h1, 32'hffff_0000, 16'h0, 1'b0, 1'b0, "R10");
    // R11: first source has no effect
    step(7, 32'h0, 32'h0, 16'h1234, 1'b1, 1'b0, "R11");
    step(7, 32'hffff_ffff, 32'h0, 16'h1234, 1'b1, 1'b0, "R11");

    // random stream across all operations, chained pairs included
    for (int i = 0; i < 800; i++) begin
      int op = int'($urandom_range(0, 15));
      logic [31:0] a = $urandom(), rb = $urandom();
      if (i % 7 == 0) a = 32'hffff_ffff;
      if (i % 11 == 0) rb = a;
      step(op, a, rb, 16'($urandom()), bit'($urandom_range(0, 1)),
           bit'($urandom_range(0, 1)), "");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule